// File: doc/BRIEF.md
# ACPI Fixed-Feature Power Management Register Block

This block holds the fixed-feature power-management registers that an operating system's ACPI driver expects to find on a small I/O-port bus. It provides an event status word, an event enable word, a sleep control word and a write-only command port. The command port switches the platform between legacy mode and ACPI mode. From the status and enable words it drives the system control interrupt as a level-sensitive, active-low line.

A power-button input is synchronised and edge-detected. While ACPI mode is on, each rising edge becomes a pending power-button event. Writing the control word with the sleep-enable bit set and the soft-off sleep type produces a single-cycle power-off request. The block answers every access to one of its ports one cycle later. Read data arrives on `io_rdata`, and an access with the wrong size is flagged on `io_reject`.

Top module: `pm_fixed_regs`

## Requirements
- R1: The status (0x400), enable (0x402) and control (0x404) ports accept only 2-byte accesses, and the command port (0xb2) accepts only 1-byte accesses. Any other size on one of these addresses raises `io_reject` in the cycle after the strobe and changes no register.
- R2: Status bit positions are timer 0, bus-master 4, global 5, power button 8, sleep button 9, RTC 10 and wake 15. A read of port 0x400 returns the status word on `io_rdata` one cycle after the read strobe.
- R3: Writing 1 clears a status bit only at positions 15, 10, 9, 8 and 4. Writing 0 changes nothing, and the other positions ignore writes.
- R4: A write to the enable port keeps only bits 8 (power button) and 5 (global), so reads of the enable port show every other bit as 0.
- R5: The interrupt is requested when, at bit 0, 5, 8, 9 or 10, the enable bit and the status bit are both 1. `sci_n` follows this condition one clock after the registers change.
- R6: `sci_n` is active low and level-sensitive. It stays low for as long as the condition holds and returns high once the pending bit is cleared or masked.
- R7: A rising edge on `pwrbtn_in` while ACPI mode is on sets status bit 8. A further edge while the bit is already set leaves the status unchanged.
- R8: A write to the control port stores the written word with bits 15, 14, 13, 1 and 0 forced to 0. Bit 0 (SCI enable) keeps its prior value.
- R9: A byte written to the command port with value 0xa0 sets control bit 0 and turns ACPI mode on. Value 0xa1 clears control bit 0 and turns ACPI mode off. Any other value is ignored.
- R10: A control write with bit 13 set and bits 12:10 equal to `S5_TYPE` (default 5) raises `poweroff_req` for exactly one cycle. Any other control write leaves `poweroff_req` low.
- R11: Power-button edges that arrive while ACPI mode is off are discarded, and status bit 8 stays 0.
- R12: After reset, status, enable and control read 0, ACPI mode is off and `sci_n` is 1. A byte read of the command port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_bytes | input | 3 | Access size in bytes |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, registered |
| io_ack | output | 1 | Access to a port of this block with the right size was accepted |
| io_reject | output | 1 | Access to a port of this block with the wrong size was refused |
| pwrbtn_in | input | 1 | Asynchronous power-button level |
| sci_n | output | 1 | Active-low level interrupt |
| poweroff_req | output | 1 | One-cycle soft-off request |

## Verification
The properties assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that each strobe lasts one cycle, and that the power button is held for at least two clocks so the synchroniser registers it. The stimulus drives every bus strobe from a task that raises it for exactly one clock between falling edges. Button presses last several cycles and are followed by a settling gap before any readback.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
  localparam int DW = 16;

  localparam logic [DW-1:0] ST_TIMER  = 16'h0001;
  localparam logic [DW-1:0] ST_BUSMST = 16'h0010;
  localparam logic [DW-1:0] ST_GLOBAL = 16'h0020;
  localparam logic [DW-1:0] ST_PWRBTN = 16'h0100;
  localparam logic [DW-1:0] ST_SLPBTN = 16'h0200;
  localparam logic [DW-1:0] ST_RTC    = 16'h0400;
  localparam logic [DW-1:0] ST_WAKE   = 16'h8000;

  // bits a guest may clear by writing one
  localparam logic [DW-1:0] CLR_MASK = ST_WAKE | ST_RTC | ST_SLPBTN | ST_PWRBTN | ST_BUSMST;
  // bits the enable word retains
  localparam logic [DW-1:0] EN_KEEP  = ST_PWRBTN | ST_GLOBAL;
  // pairs that can raise the interrupt
  localparam logic [DW-1:0] IRQ_SRC  = ST_TIMER | ST_GLOBAL | ST_PWRBTN | ST_SLPBTN | ST_RTC;

  localparam logic [DW-1:0] CT_SCIEN  = 16'h0001;
  localparam logic [DW-1:0] CT_SLPEN  = 16'h2000;
  localparam logic [DW-1:0] CT_ZERO   = 16'hc003;
  localparam int            CT_TYP_LO = 10;
  localparam int            CT_TYP_W  = 3;
  localparam int            CT_EN_BIT = 13;

  typedef struct packed {
    logic sts;
    logic en;
    logic ctl;
    logic cmd;
  } port_sel_t;
endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STS_PORT = 16'h0400,
  parameter logic [ADDR_W-1:0] EN_PORT  = 16'h0402,
  parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_PORT = 16'h00b2
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [2:0]             bytes,
  input  logic                   strobe,
  output pm_regs_pkg::port_sel_t sel,
  output logic                   bad_size
);
  import pm_regs_pkg::*;

  localparam logic [2:0] WORD_SZ = 3'd2;
  localparam logic [2:0] BYTE_SZ = 3'd1;

  port_sel_t hit;

  always_comb begin
    hit.sts = (addr == STS_PORT);
    hit.en  = (addr == EN_PORT);
    hit.ctl = (addr == CTL_PORT);
    hit.cmd = (addr == CMD_PORT);
  end

  logic word_ok, byte_ok;
  assign word_ok = (bytes == WORD_SZ);
  assign byte_ok = (bytes == BYTE_SZ);

  always_comb begin
    sel.sts  = strobe & hit.sts & word_ok;
    sel.en   = strobe & hit.en  & word_ok;
    sel.ctl  = strobe & hit.ctl & word_ok;
    sel.cmd  = strobe & hit.cmd & byte_ok;
    bad_size = strobe & (((hit.sts | hit.en | hit.ctl) & ~word_ok) |
                         (hit.cmd & ~byte_ok));
  end
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sts,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          btn_async,
  input  logic          armed,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] enable_q,
  output logic          btn_rise
);
  import pm_regs_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   btn_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= btn_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], btn_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) btn_prev <= 1'b0;
    else     btn_prev <= sync_q[SYNC_STAGES-1];
  end

  assign btn_rise = sync_q[SYNC_STAGES-1] & ~btn_prev;

  logic [DW-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (wr_sts)
      status_d = status_d & ~(wdata & CLR_MASK);
    if (btn_rise && armed)
      status_d = status_d | ST_PWRBTN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (wr_en)
        enable_q <= wdata & EN_KEEP;
    end
  end
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs #(
  parameter int         DW      = 16,
  parameter logic [2:0] S5_TYPE = 3'd5,
  parameter logic [7:0] CMD_ON  = 8'ha0,
  parameter logic [7:0] CMD_OFF = 8'ha1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic          armed,
  output logic          poweroff_q
);
  import pm_regs_pkg::*;

  logic [DW-1:0] ctrl_d;
  logic          sleep_go;

  assign sleep_go = wr_ctl & wdata[CT_EN_BIT] &
                    (wdata[CT_TYP_LO +: CT_TYP_W] == S5_TYPE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctl)
      ctrl_d = (ctrl_q & CT_SCIEN) | (wdata & ~(CT_SLPEN | CT_ZERO));
    if (wr_cmd) begin
      if (wdata[7:0] == CMD_ON)
        ctrl_d = ctrl_d | CT_SCIEN;
      else if (wdata[7:0] == CMD_OFF)
        ctrl_d = ctrl_d & ~CT_SCIEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      poweroff_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      poweroff_q <= sleep_go;
    end
  end

  assign armed = ctrl_q[0];
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] enable,
  output logic          sci_n
);
  import pm_regs_pkg::*;

  logic want;
  assign want = |(status & enable & IRQ_SRC);

  always_ff @(posedge clk) begin
    if (rst) sci_n <= 1'b1;
    else     sci_n <= ~want;
  end
endmodule

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs #(
  parameter int          ADDR_W      = 16,
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  S5_TYPE     = 3'd5,
  parameter logic [15:0] STS_PORT    = 16'h0400,
  parameter logic [15:0] EN_PORT     = 16'h0402,
  parameter logic [15:0] CTL_PORT    = 16'h0404,
  parameter logic [15:0] CMD_PORT    = 16'h00b2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [2:0]        io_bytes,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_ack,
  output logic              io_reject,
  input  logic              pwrbtn_in,
  output logic              sci_n,
  output logic              poweroff_req
);
  import pm_regs_pkg::*;

  port_sel_t wsel, rsel;
  logic      wbad, rbad;

  pm_bus_decode #(.ADDR_W(ADDR_W), .STS_PORT(STS_PORT), .EN_PORT(EN_PORT),
                  .CTL_PORT(CTL_PORT), .CMD_PORT(CMD_PORT)) u_wdec (
    .addr(io_addr), .bytes(io_bytes), .strobe(io_wr), .sel(wsel), .bad_size(wbad));

  pm_bus_decode #(.ADDR_W(ADDR_W), .STS_PORT(STS_PORT), .EN_PORT(EN_PORT),
                  .CTL_PORT(CTL_PORT), .CMD_PORT(CMD_PORT)) u_rdec (
    .addr(io_addr), .bytes(io_bytes), .strobe(io_rd), .sel(rsel), .bad_size(rbad));

  logic [DW-1:0] status_q, enable_q, ctrl_q;
  logic          armed, btn_rise;

  pm_event_regs #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst(rst), .wr_sts(wsel.sts), .wr_en(wsel.en), .wdata(io_wdata),
    .btn_async(pwrbtn_in), .armed(armed), .status_q(status_q), .enable_q(enable_q),
    .btn_rise(btn_rise));

  pm_ctrl_regs #(.DW(DW), .S5_TYPE(S5_TYPE)) u_ctl (
    .clk(clk), .rst(rst), .wr_ctl(wsel.ctl), .wr_cmd(wsel.cmd), .wdata(io_wdata),
    .ctrl_q(ctrl_q), .armed(armed), .poweroff_q(poweroff_req));

  pm_sci_gen #(.DW(DW)) u_sci (
    .clk(clk), .rst(rst), .status(status_q), .enable(enable_q), .sci_n(sci_n));

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rsel.sts) rd_mux = status_q;
    if (rsel.en)  rd_mux = enable_q;
    if (rsel.ctl) rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_ack    <= 1'b0;
      io_reject <= 1'b0;
    end else begin
      io_rdata  <= rd_mux;
      io_ack    <= (|wsel) | (|rsel);
      io_reject <= wbad | rbad;
    end
  end
endmodule

// File: rtl/pm_fixed_regs_chk.sv
module pm_fixed_regs_chk #(
  parameter logic [2:0] S5_TYPE = 3'd5
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic [2:0]  io_bytes,
  input logic        io_wr,
  input logic [15:0] io_wdata,
  input logic [15:0] status_q,
  input logic [15:0] enable_q,
  input logic [15:0] ctrl_q,
  input logic        sci_n,
  input logic        poweroff_req
);
  logic ctl_wr, wide_bad;
  assign ctl_wr   = io_wr && io_addr == 16'h0404 && io_bytes == 3'd2;
  assign wide_bad = io_wr && io_bytes != 3'd2 &&
                    (io_addr == 16'h0400 || io_addr == 16'h0402 || io_addr == 16'h0404);

  AST_BAD_SIZE_NOP: assert property (@(posedge clk) disable iff (rst)
    $past(wide_bad) |-> (enable_q == $past(enable_q) && ctrl_q == $past(ctrl_q))); // R1
  AST_NEW_STATUS_PWR: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q)) == 16'h0000) ||
    ((status_q & ~$past(status_q)) == 16'h0100)); // R7
  AST_FIXED_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status_q & 16'h0021) == ($past(status_q) & 16'h0021)); // R3
  AST_ENABLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (enable_q & 16'hfedf) == 16'h0000); // R4
  AST_SCI_LEVEL: assert property (@(posedge clk) disable iff (rst)
    sci_n == !$past(|(status_q & enable_q & 16'h0721))); // R5
  AST_SCIEN_KEPT: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_wr) |-> ctrl_q[0] == $past(ctrl_q[0])); // R8
  AST_POWEROFF_SRC: assert property (@(posedge clk) disable iff (rst)
    poweroff_req |-> $past(ctl_wr && io_wdata[13] && io_wdata[12:10] == S5_TYPE)); // R10
  AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[8]) |-> $past(ctrl_q[0])); // R11
endmodule

bind pm_fixed_regs pm_fixed_regs_chk #(.S5_TYPE(S5_TYPE)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_bytes(io_bytes), .io_wr(io_wr),
  .io_wdata(io_wdata), .status_q(status_q), .enable_q(enable_q), .ctrl_q(ctrl_q),
  .sci_n(sci_n), .poweroff_req(poweroff_req));

// File: tb/tb_pm_fixed_regs.sv
`timescale 1ns/1ps
module tb_pm_fixed_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_bytes = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_ack, io_reject;
  logic        pwrbtn_in = 1'b0;
  logic        sci_n, poweroff_req;

  int checks = 0, fails = 0, pw_cnt = 0;

  always #4 clk = ~clk;

  pm_fixed_regs dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_bytes(io_bytes), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .io_reject(io_reject), .pwrbtn_in(pwrbtn_in), .sci_n(sci_n),
    .poweroff_req(poweroff_req));

  always @(negedge clk) if (!rst && poweroff_req) pw_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [2:0] b, input logic [15:0] d,
                        output logic rej);
    @(negedge clk);
    io_addr = a; io_bytes = b; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    rej = io_reject;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [2:0] b,
                        output logic [15:0] d, output logic rej);
    @(negedge clk);
    io_addr = a; io_bytes = b; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; rej = io_reject;
  endtask

  task automatic press;
    @(negedge clk); pwrbtn_in = 1'b1;
    repeat (3) @(negedge clk);
    pwrbtn_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // {kind(2): 0 write / 1 read-compare, addr(16), bytes(4), data(16), req(8)}
  localparam int NV = 20;
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 16'h0400, 4'd2, 16'h0000, 8'd12},
    {2'd1, 16'h0402, 4'd2, 16'h0000, 8'd12},
    {2'd1, 16'h0404, 4'd2, 16'h0000, 8'd12},
    {2'd1, 16'h00b2, 4'd1, 16'h0000, 8'd12},
    {2'd0, 16'h0402, 4'd2, 16'hffff, 8'd4},
    {2'd1, 16'h0402, 4'd2, 16'h0120, 8'd4},
    {2'd0, 16'h0404, 4'd2, 16'hffff, 8'd8},
    {2'd1, 16'h0404, 4'd2, 16'h1ffc, 8'd8},
    {2'd0, 16'h0404, 4'd2, 16'h0000, 8'd8},
    {2'd0, 16'h0402, 4'd4, 16'h0000, 8'd1},
    {2'd1, 16'h0402, 4'd2, 16'h0120, 8'd1},
    {2'd0, 16'h00b2, 4'd1, 16'h00a0, 8'd9},
    {2'd1, 16'h0404, 4'd2, 16'h0001, 8'd9},
    {2'd0, 16'h0404, 4'd2, 16'h0000, 8'd8},
    {2'd1, 16'h0404, 4'd2, 16'h0001, 8'd8},
    {2'd0, 16'h00b2, 4'd1, 16'h0055, 8'd9},
    {2'd1, 16'h0404, 4'd2, 16'h0001, 8'd9},
    {2'd0, 16'h00b2, 4'd2, 16'h00a1, 8'd1},
    {2'd1, 16'h0404, 4'd2, 16'h0001, 8'd1},
    {2'd0, 16'h00b2, 4'd1, 16'h00a1, 8'd9}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        rj;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(sci_n === 1'b1, "R12 sci_n idle after reset", sci_n, 1);
    check(poweroff_req === 1'b0, "R12 no poweroff after reset", poweroff_req, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [15:0] a, v;
      logic [3:0]  b;
      logic [7:0]  r;
      {k, a, b, v, r} = VEC[i];
      if (k == 2'd0) bus_wr(a, b[2:0], v, rj);
      else begin
        bus_rd(a, b[2:0], d, rj);
        check(d === v, $sformatf("R%0d table vector %0d", r, i), d, v);
      end
    end
    bus_rd(16'h0404, 3'd2, d, rj);
    check(d === 16'h0000, "R9 disable clears control bit 0", d, 0);

    // R1 rejects, by size
    bus_wr(16'h0400, 3'd1, 16'h0000, rj);
    check(rj === 1'b1, "R1 byte write to status rejected", rj, 1);
    bus_rd(16'h0402, 3'd4, d, rj);
    check(rj === 1'b1 && d === 16'h0, "R1 dword read of enable rejected", {rj, d}, 17'h10000);
    bus_rd(16'h0400, 3'd2, d, rj);
    check(rj === 1'b0 && io_ack === 1'b1, "R1 word read accepted", rj, 0);

    // R11 disarmed button
    press();
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0000, "R11 edge while disarmed discarded", d, 0);
    check(sci_n === 1'b1, "R11 no interrupt while disarmed", sci_n, 1);

    // arm and enable power button
    bus_wr(16'h00b2, 3'd1, 16'h00a0, rj);
    bus_wr(16'h0402, 3'd2, 16'h0100, rj);
    press();
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0100, "R2 R7 button sets status bit 8", d, 16'h0100);
    check(sci_n === 1'b0, "R5 R6 interrupt asserted low", sci_n, 0);
    press();
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0100, "R7 second edge leaves status unchanged", d, 16'h0100);

    bus_wr(16'h0400, 3'd2, 16'h0000, rj);
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0100, "R3 writing zeros keeps status", d, 16'h0100);
    bus_wr(16'h0400, 3'd2, 16'hfeff, rj);
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0100, "R3 other bits do not clear bit 8", d, 16'h0100);
    check(sci_n === 1'b0, "R6 level held while pending", sci_n, 0);

    bus_wr(16'h0402, 3'd2, 16'h0020, rj);
    @(negedge clk);
    check(sci_n === 1'b1, "R5 masking drops interrupt", sci_n, 1);
    bus_wr(16'h0402, 3'd2, 16'h0100, rj);
    @(negedge clk);
    check(sci_n === 1'b0, "R5 unmask raises interrupt", sci_n, 0);
    bus_wr(16'h0400, 3'd2, 16'h0100, rj);
    @(negedge clk);
    bus_rd(16'h0400, 3'd2, d, rj);
    check(d === 16'h0000, "R3 write-one clears bit 8", d, 0);
    check(sci_n === 1'b1, "R6 interrupt released after clear", sci_n, 1);

    // R10 power-off
    bus_wr(16'h0404, 3'd2, 16'h1400, rj);
    @(negedge clk);
    check(pw_cnt == 0, "R10 soft-off type without enable bit", pw_cnt, 0);
    bus_wr(16'h0404, 3'd2, 16'h2c00, rj);
    @(negedge clk);
    check(pw_cnt == 0, "R10 enable bit with other type", pw_cnt, 0);
    bus_wr(16'h0404, 3'd2, 16'h3400, rj);
    repeat (3) @(negedge clk);
    check(pw_cnt == 1, "R10 single pulse on soft-off", pw_cnt, 1);
    bus_rd(16'h0404, 3'd2, d, rj);
    check(d === 16'h1401, "R8 stored control drops enable bit, keeps bit 0", d, 16'h1401);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule